// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter. Software programs it through a small set of control fields: a module enable, a start/busy bit, a two-bit conversion clock select and an interrupt enable. Once started, the block produces a per-bit conversion clock. That clock comes either from dividing the system clock or from a slow free-running RC tick input. On each period the block presents a trial code to the external DAC, reads back a single comparator bit and settles one result bit, most significant first.

A conversion ends in one of two ways. If it completes, the settled code goes to the result register, the start bit clears by itself and a sticky completion flag is set. That flag, together with the interrupt enable and a peripheral enable input, forms a wake/interrupt request. If it is aborted, the result and the flag are left alone. Three things abort a conversion: software clearing the start bit, reset, and entering sleep while a divided system clock is selected. With the RC tick selected, conversions run on through sleep, and the first RC periods are held off for a short start delay. The comparator, DAC and input multiplexer are outside the block.

Top module: `sar_seq`

## Requirements
- R1: `ctrl_clksel` picks the conversion period. Value 0 gives 2 system clocks, value 1 gives 8, value 2 gives 32, and value 3 makes one period per `rc_tick` pulse.
- R2: A conversion lasts exactly 9 conversion periods. With a divided clock of N, `go_o` is high for exactly 9·N system clock cycles after the write that starts it.
- R3: On completion, the settled code appears on `result_o`, `go_o` drops and `done_o` rises, all on the same clock edge.
- R4: A control write with `ctrl_go`=0 during a conversion aborts it. `result_o` keeps its previous value and `done_o` stays low.
- R5: After `go_o` has dropped, whether by completion or by abort, a new start write begins a fresh conversion that finishes normally.
- R6: With the RC source selected, `rc_tick` pulses sampled in the first RC_DLY (default 4) system clock cycles after the start edge are ignored. Conversion periods are counted only after that.
- R7: While `sleep_i` is high and a divided source (values 0–2) is selected, a running conversion aborts on the next edge. `pwr_o` goes low and `en_o` stays high, with no result update and no flag.
- R8: With the RC source selected, a conversion completes during sleep. `wake_o` is high exactly when `done_o`, the interrupt enable and `periph_en` are all high. If a completion during sleep has no wake, `pwr_o` goes low and `en_o` stays high.
- R9: Reset clears the enable, the start bit, the clock select, the interrupt enable and the flag, and aborts any conversion in progress.
- R10: Trials run MSB first. The first period only samples. At the end of that period the trial code is 0x80. A comparator value of 1 keeps the bit under trial, and 0 clears it.
- R11: A start write is ignored when the module was disabled before that write. This includes a write that sets enable and start together.
- R12: `done_o` stays set until a `flag_clr` pulse clears it. A completion in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable value written |
| ctrl_go | input | 1 | Start/busy value written |
| ctrl_clksel | input | 2 | Conversion clock select written |
| ctrl_ie | input | 1 | Interrupt enable written |
| flag_clr | input | 1 | Write-one-to-clear pulse for the done flag |
| periph_en | input | 1 | Peripheral interrupt enable |
| sleep_i | input | 1 | Device is in sleep |
| rc_tick | input | 1 | One-cycle pulse per RC oscillator period |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial code |
| en_o | output | 1 | Module enable bit |
| go_o | output | 1 | Start/busy bit |
| done_o | output | 1 | Completion flag |
| wake_o | output | 1 | Wake/interrupt request |
| pwr_o | output | 1 | Converter powered (enabled and not shut down) |
| trial_o | output | 8 | Trial code to the DAC |
| result_o | output | 8 | Result register |

## Verification
A wrong period counter or a divider that is off by one shows directly as a busy window that is not a multiple of 9·N cycles. A trial register that settles the wrong bit gives a result different from the comparator target as soon as `go_o` drops. Faulty abort paths show up within one cycle: either the flag rises, or the result changes, after software clears the start bit or sleep begins. Mistakes in the RC start delay appear as a conversion that ends one RC pulse early.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        CLK_DIV_A = 2'd0,
        CLK_DIV_B = 2'd1,
        CLK_DIV_C = 2'd2,
        CLK_RC    = 2'd3
    } clksel_e;

    typedef struct packed {
        logic    en;
        logic    go;
        logic    ie;
        logic    done;
        logic    off;
        clksel_e sel;
    } ctl_t;
endpackage

// File: rtl/sar_clkgen.sv
module sar_clkgen #(
    parameter int DIV_A  = 2,
    parameter int DIV_B  = 8,
    parameter int DIV_C  = 32,
    parameter int RC_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  sar_pkg::clksel_e  sel,
    input  logic              rc_tick,
    output logic              tick_o
);
    localparam int MAXV = (DIV_C > RC_DLY) ? DIV_C : RC_DLY + 1;
    localparam int CW   = $clog2(MAXV + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (sel)
            sar_pkg::CLK_DIV_A: lim = CW'(DIV_A - 1);
            sar_pkg::CLK_DIV_B: lim = CW'(DIV_B - 1);
            sar_pkg::CLK_DIV_C: lim = CW'(DIV_C - 1);
            default:            lim = CW'(RC_DLY);
        endcase
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (run) begin
            if (sel == sar_pkg::CLK_RC) begin
                if (cnt_q < lim) cnt_d = cnt_q + 1'b1;
                else             tick_o = rc_tick;
            end else if (cnt_q == lim) begin
                tick_o = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         run,
    input  logic         tick,
    input  logic         cmp_i,
    output logic [W-1:0] code_o,
    output logic [W-1:0] code_nx_o,
    output logic         last_o
);
    localparam int PW = $clog2(W + 1);

    typedef struct packed {
        logic [PW-1:0] ph;
        logic [W-1:0]  code;
    } st_t;

    st_t d, q;
    int  idx;

    always_comb begin
        d      = q;
        idx    = W - int'(q.ph);
        last_o = run && tick && (q.ph == PW'(W));
        if (load) begin
            d.ph   = '0;
            d.code = '0;
        end else if (run && tick) begin
            if (q.ph == '0) begin
                d.code[W-1] = 1'b1;
                d.ph        = PW'(1);
            end else begin
                d.code[idx] = cmp_i;
                if (idx > 0) d.code[idx-1] = 1'b1;
                d.ph = last_o ? '0 : q.ph + 1'b1;
            end
        end
        code_nx_o = d.code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code_o = q.code;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int W      = 8,
    parameter int DIV_A  = 2,
    parameter int DIV_B  = 8,
    parameter int DIV_C  = 32,
    parameter int RC_DLY = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_we,
    input  logic         ctrl_en,
    input  logic         ctrl_go,
    input  logic [1:0]   ctrl_clksel,
    input  logic         ctrl_ie,
    input  logic         flag_clr,
    input  logic         periph_en,
    input  logic         sleep_i,
    input  logic         rc_tick,
    input  logic         cmp_i,
    output logic         en_o,
    output logic         go_o,
    output logic         done_o,
    output logic         wake_o,
    output logic         pwr_o,
    output logic [W-1:0] trial_o,
    output logic [W-1:0] result_o
);
    import sar_pkg::*;

    ctl_t         ctl_d, ctl_q;
    logic [W-1:0] res_q;
    logic [W-1:0] code_nx;
    logic         tick, last;
    logic         start, sw_abort, slp_abort, finish;

    sar_clkgen #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .RC_DLY(RC_DLY)
    ) u_clk (
        .clk(clk), .rst_n(rst_n), .restart(start), .run(ctl_q.go),
        .sel(ctl_q.sel), .rc_tick(rc_tick), .tick_o(tick)
    );

    sar_trial #(.W(W)) u_trial (
        .clk(clk), .rst_n(rst_n), .load(start), .run(ctl_q.go),
        .tick(tick), .cmp_i(cmp_i), .code_o(trial_o),
        .code_nx_o(code_nx), .last_o(last)
    );

    always_comb begin
        ctl_d     = ctl_q;
        start     = ctrl_we && ctrl_go && ctrl_en && ctl_q.en && !ctl_q.go;
        sw_abort  = ctl_q.go && ctrl_we && (!ctrl_go || !ctrl_en);
        slp_abort = ctl_q.go && sleep_i && (ctl_q.sel != CLK_RC);
        finish    = ctl_q.go && last && !sw_abort && !slp_abort;

        if (ctrl_we) begin
            ctl_d.en  = ctrl_en;
            ctl_d.ie  = ctrl_ie;
            ctl_d.sel = clksel_e'(ctrl_clksel);
        end

        if (start)                               ctl_d.go = 1'b1;
        else if (finish || sw_abort || slp_abort) ctl_d.go = 1'b0;

        if (finish)        ctl_d.done = 1'b1;
        else if (flag_clr) ctl_d.done = 1'b0;

        if (start)
            ctl_d.off = 1'b0;
        else if (slp_abort || (finish && sleep_i && !(ctl_q.ie && periph_en)))
            ctl_d.off = 1'b1;
        else if (!sleep_i)
            ctl_d.off = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.en   <= 1'b0;
            ctl_q.go   <= 1'b0;
            ctl_q.ie   <= 1'b0;
            ctl_q.done <= 1'b0;
            ctl_q.off  <= 1'b0;
            ctl_q.sel  <= CLK_DIV_A;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        if (finish) res_q <= code_nx;
    end

    assign en_o     = ctl_q.en;
    assign go_o     = ctl_q.go;
    assign done_o   = ctl_q.done;
    assign wake_o   = ctl_q.done && ctl_q.ie && periph_en;
    assign pwr_o    = ctl_q.en && !ctl_q.off;
    assign result_o = res_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_o,
    input logic         go_o,
    input logic         done_o,
    input logic         wake_o,
    input logic         flag_clr,
    input logic         periph_en,
    input logic         sleep_i,
    input logic [1:0]   sel,
    input logic         ie,
    input logic [W-1:0] result_o
);
    a_r3_flag_with_go_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(go_o));

    a_r4_result_kept_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go_o) && !$rose(done_o)) |-> $stable(result_o));

    a_r7_sleep_aborts_divided: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && sleep_i && sel != 2'd3) |=> !go_o);

    a_r8_wake_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (done_o && ie && periph_en));

    a_r11_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> !go_o);

    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !flag_clr) |=> done_o);
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_o(en_o), .go_o(go_o), .done_o(done_o),
    .wake_o(wake_o), .flag_clr(flag_clr), .periph_en(periph_en),
    .sleep_i(sleep_i), .sel(ctl_q.sel), .ie(ctl_q.ie), .result_o(result_o)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
    localparam int RC_DLY = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0, ctrl_en = 1'b0, ctrl_go = 1'b0, ctrl_ie = 1'b0;
    logic [1:0] ctrl_clksel = 2'd0;
    logic       flag_clr = 1'b0, periph_en = 1'b0, sleep_i = 1'b0, rc_tick = 1'b0;
    logic       cmp_i;
    logic       en_o, go_o, done_o, wake_o, pwr_o;
    logic [7:0] trial_o, result_o;
    logic [7:0] target = 8'h00;

    int errors = 0;
    int checks = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    assign cmp_i = (target >= trial_o);

    sar_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_en(ctrl_en),
        .ctrl_go(ctrl_go), .ctrl_clksel(ctrl_clksel), .ctrl_ie(ctrl_ie),
        .flag_clr(flag_clr), .periph_en(periph_en), .sleep_i(sleep_i),
        .rc_tick(rc_tick), .cmp_i(cmp_i), .en_o(en_o), .go_o(go_o),
        .done_o(done_o), .wake_o(wake_o), .pwr_o(pwr_o),
        .trial_o(trial_o), .result_o(result_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic en, input logic go, input logic [1:0] sel, input logic ie);
        ctrl_we = 1'b1; ctrl_en = en; ctrl_go = go; ctrl_clksel = sel; ctrl_ie = ie;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic rc_pulse();
        rc_tick = 1'b1;
        @(negedge clk);
        rc_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_reset_state();
        check("R9 en after reset", en_o, 0);
        check("R9 go after reset", go_o, 0);
        check("R9 done after reset", done_o, 0);
        check("R9 wake after reset", wake_o, 0);
        check("R9 pwr after reset", pwr_o, 0);
    endtask

    task automatic t_divided(input logic [1:0] sel, input int div, input logic [7:0] tgt);
        int n;
        target = tgt;
        wr(1'b1, 1'b0, sel, 1'b0);
        clear_flag();
        wr(1'b1, 1'b1, sel, 1'b0);
        n = 0;
        while (go_o && n < 1000) begin
            n++;
            if (n == div + 1) check("R10 first trial code", trial_o, 8'h80);
            @(negedge clk);
        end
        check("R1 R2 busy cycles", n, 9 * div);
        check("R3 result", result_o, tgt);
        check("R3 done set", done_o, 1);
    endtask

    task automatic t_flag_wake();
        periph_en = 1'b1;
        wr(1'b1, 1'b0, 2'd0, 1'b1);
        check("R8 wake with both enables", wake_o, 1);
        periph_en = 1'b0;
        #1;
        check("R8 wake without peripheral enable", wake_o, 0);
        cyc(3);
        check("R12 flag held", done_o, 1);
        clear_flag();
        check("R12 flag cleared", done_o, 0);
    endtask

    task automatic t_abort();
        logic [7:0] old;
        old = result_o;
        target = ~old;
        wr(1'b1, 1'b1, 2'd1, 1'b0);
        cyc(20);
        wr(1'b1, 1'b0, 2'd1, 1'b0);
        check("R4 go cleared by abort", go_o, 0);
        cyc(80);
        check("R4 result unchanged", result_o, old);
        check("R4 no flag", done_o, 0);
        t_divided(2'd0, 2, 8'h3C);
        check("R5 restart completes", result_o, 8'h3C);
    endtask

    task automatic t_no_start();
        wr(1'b0, 1'b0, 2'd0, 1'b0);
        wr(1'b1, 1'b1, 2'd0, 1'b0);
        check("R11 start with enable ignored", go_o, 0);
        cyc(1);
        check("R11 still idle", go_o, 0);
        wr(1'b0, 1'b0, 2'd0, 1'b0);
        wr(1'b0, 1'b1, 2'd0, 1'b0);
        check("R11 start while disabled ignored", go_o, 0);
    endtask

    task automatic t_rc_delay();
        target = 8'hA7;
        clear_flag();
        wr(1'b1, 1'b0, 2'd3, 1'b0);
        wr(1'b1, 1'b1, 2'd3, 1'b0);
        rc_pulse();
        cyc(RC_DLY);
        for (int i = 0; i < 8; i++) rc_pulse();
        check("R6 early pulse ignored, still busy", go_o, 1);
        rc_pulse();
        check("R6 R1 done after 9 counted pulses", go_o, 0);
        check("R6 result", result_o, 8'hA7);
    endtask

    task automatic t_sleep_div();
        logic [7:0] old;
        old = result_o;
        target = 8'h11;
        clear_flag();
        wr(1'b1, 1'b0, 2'd2, 1'b0);
        wr(1'b1, 1'b1, 2'd2, 1'b0);
        cyc(40);
        sleep_i = 1'b1;
        cyc(1);
        check("R7 aborted by sleep", go_o, 0);
        check("R7 powered down", pwr_o, 0);
        check("R7 enable kept", en_o, 1);
        cyc(300);
        check("R7 no flag", done_o, 0);
        check("R7 result unchanged", result_o, old);
        sleep_i = 1'b0;
        cyc(1);
    endtask

    task automatic t_sleep_rc(input logic ie, input logic [7:0] tgt);
        target = tgt;
        periph_en = 1'b1;
        clear_flag();
        wr(1'b1, 1'b0, 2'd3, ie);
        wr(1'b1, 1'b1, 2'd3, ie);
        sleep_i = 1'b1;
        cyc(RC_DLY + 2);
        for (int i = 0; i < 9; i++) rc_pulse();
        check("R8 completes in sleep", done_o, 1);
        check("R8 result in sleep", result_o, tgt);
        check("R8 wake", wake_o, ie);
        check("R8 power state", pwr_o, ie);
        check("R8 enable kept", en_o, 1);
        sleep_i = 1'b0;
        periph_en = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset_mid();
        wr(1'b1, 1'b0, 2'd2, 1'b1);
        wr(1'b1, 1'b1, 2'd2, 1'b1);
        cyc(50);
        rst_n = 1'b0;
        cyc(1);
        check("R9 go cleared by reset", go_o, 0);
        check("R9 en cleared by reset", en_o, 0);
        check("R9 flag cleared by reset", done_o, 0);
        rst_n = 1'b1;
        cyc(100);
        check("R9 stays idle", go_o, 0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_divided(2'd0, 2, 8'h5A);
        t_divided(2'd1, 8, 8'hFF);
        t_divided(2'd2, 32, 8'h00);
        t_divided(2'd0, 2, 8'h81);
        t_flag_wake();
        t_abort();
        t_no_start();
        t_rc_delay();
        t_sleep_div();
        t_sleep_rc(1'b0, 8'h6E);
        t_sleep_rc(1'b1, 8'hC3);
        t_reset_mid();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule